// File: doc/BRIEF.md
# Video Controller Host Port

This block sits between a processor bus and the pixel engine of a tile-and-sprite video controller. The processor sees two byte-wide ports, chosen by one select bit: a data port that streams bytes to and from video memory, and a control port. Writes to the control port form two-byte commands that either load one of eight configuration registers or point the memory pointer at a new location. Reads of the control port return a status byte, which is then cleared. The register contents, the decoded display mode, the display enable and a level interrupt are driven out to the rest of the controller. The pixel engine raises status flags through three event inputs.

Two small state machines carry the behaviour. The command stage machine has states `STAGE_FIRST` and `STAGE_SECOND`. A control write in `STAGE_FIRST` holds the byte and moves to `STAGE_SECOND`. A control write in `STAGE_SECOND` executes the command and returns to `STAGE_FIRST`. Any data port access or status read also forces `STAGE_FIRST`. The prefetch machine has states `PF_IDLE` and `PF_LOAD`. A read setup or a data port read starts a memory read and enters `PF_LOAD`. On the following clock the memory output is copied into the read buffer and the machine returns to `PF_IDLE`. Video memory is a synchronous RAM inside the block. Its depth is a parameter, and pointer values that differ only above the stored bits reach the same byte.

Top module: `vdp_host_port`

## Requirements
- R1: After reset, all eight registers read 0, the status byte is 0, the command stage is the first, `rdata` is 0, `mode_o` is 0, and `disp_en_o` and `irq_o` are low.
- R2: A second control byte with bit 7 set writes the held first byte into the register whose index is bits 2:0 of the second byte, so index 8 lands in register 0. Register n appears on `regs_o[8n+7:8n]`. Registers change on no other access.
- R3: A second control byte with bits 7:6 = 01 loads the pointer with bits 5:0 as the high part and the held byte as the low byte. Each data port write stores `wdata` at the pointer, and the pointer then advances by one.
- R4: A second control byte with bits 7:6 = 00 loads the pointer the same way, fetches the addressed byte into the read buffer and advances the pointer. Each data port read returns the buffered byte on `rdata`, fetches the next byte and advances again.
- R5: The 14-bit pointer wraps from 0x3FFF to 0x0000 on both reads and writes.
- R6: A data port read or write, or a status read, returns the command stage to the first stage. A following two-byte sequence is then decoded from its own first byte.
- R7: A control port read puts the status byte on `rdata` and clears the status. An event that arrives in the same cycle as the read stays set.
- R8: Status bit 7 is set by `frame_evt`. Bit 6 is set by `fifth_evt`, which also loads `fifth_idx` into bits 4:0. Bit 5 is set by `coll_evt`.
- R9: `mode_o` encodes 1 = bitmap-tile, 2 = text, 3 = multicolor, 0 = plain tile. Register 0 bit 1 selects 1 ahead of everything. Otherwise register 1 bit 4 selects 2, then register 1 bit 3 selects 3.
- R10: `disp_en_o` follows register 1 bit 6. `irq_o` is high exactly while status bit 7 and register 1 bit 5 are both set, so a status read drops it.
- R11: Video memory holds 2^STORE_AW bytes. Pointer values equal in their low STORE_AW bits address the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | One-cycle access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ctl | input | 1 | 0 = data port, 1 = control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered, valid from the clock after a read |
| frame_evt | input | 1 | Sets the frame flag |
| fifth_evt | input | 1 | Sets the overflow-sprite flag and loads its index |
| fifth_idx | input | 5 | Sprite index stored with the overflow flag |
| coll_evt | input | 1 | Sets the collision flag |
| regs_o | output | 64 | All eight registers, register n at bits 8n+7:8n |
| mode_o | output | 2 | Decoded display mode |
| disp_en_o | output | 1 | Display enable |
| irq_o | output | 1 | Level frame interrupt |

## Verification
The bench builds the block with a full 14-bit pointer (ADDR_W = 14) and 1 KB of storage (STORE_AW = 10). With these values the top-of-space wrap at 0x3FFF can be exercised. The same values make aliasing visible: a byte written at 0x0005 reads back from 0x0405. Directed tasks step through register loads, out-of-range register indices, all mode bit combinations, streaming writes and read-ahead, and stage resets after each kind of access. Further tasks cover status set and clear, including an event that lands in the same cycle as the status read.

// File: rtl/vhp_pkg.sv
package vhp_pkg;
    localparam int unsigned REG_IDX_W = 3;
    localparam int unsigned NUM_REGS  = 1 << REG_IDX_W;
    localparam int unsigned REGS_W    = 8 * NUM_REGS;

    localparam int unsigned ST_FRAME_BIT = 7;
    localparam int unsigned ST_FIFTH_BIT = 6;
    localparam int unsigned ST_COLL_BIT  = 5;

    typedef enum logic [1:0] {
        MODE_TILE   = 2'd0,
        MODE_BITMAP = 2'd1,
        MODE_TEXT   = 2'd2,
        MODE_MULTI  = 2'd3
    } vmode_e;

    typedef enum logic {
        STAGE_FIRST  = 1'b0,
        STAGE_SECOND = 1'b1
    } stage_e;

    typedef enum logic {
        PF_IDLE = 1'b0,
        PF_LOAD = 1'b1
    } pf_e;
endpackage

// File: rtl/vhp_cmd_latch.sv
module vhp_cmd_latch
    import vhp_pkg::*;
#(
    parameter int unsigned ADDR_W = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_wr,
    input  logic                 stage_clr,
    input  logic [7:0]           wbyte,
    output stage_e               stage_o,
    output logic                 reg_we,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic [7:0]           reg_val,
    output logic                 addr_ld,
    output logic [ADDR_W-1:0]    addr_val,
    output logic                 fetch_req
);
    localparam int unsigned HI_W = ADDR_W - 8;

    stage_e     state_q, state_d;
    logic [7:0] hold_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STAGE_FIRST:  if (ctl_wr) state_d = STAGE_SECOND;
            STAGE_SECOND: if (ctl_wr || stage_clr) state_d = STAGE_FIRST;
            default:      state_d = STAGE_FIRST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= STAGE_FIRST;
            hold_q  <= 8'h00;
        end else begin
            state_q <= state_d;
            if (ctl_wr && state_q == STAGE_FIRST) hold_q <= wbyte;
        end
    end

    always_comb begin
        reg_we    = ctl_wr && (state_q == STAGE_SECOND) && wbyte[7];
        addr_ld   = ctl_wr && (state_q == STAGE_SECOND) && !wbyte[7];
        fetch_req = addr_ld && !wbyte[6];
        reg_idx   = wbyte[REG_IDX_W-1:0];
        reg_val   = hold_q;
        addr_val  = {wbyte[HI_W-1:0], hold_q};
        stage_o   = state_q;
    end
endmodule

// File: rtl/vhp_regfile.sv
module vhp_regfile
    import vhp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [7:0]           val,
    output logic [REGS_W-1:0]    regs_flat,
    output vmode_e               mode,
    output logic                 disp_en,
    output logic                 irq_en
);
    logic [7:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                          regs_q[g] <= 8'h00;
            else if (we && idx == REG_IDX_W'(g)) regs_q[g] <= val;
        end
        assign regs_flat[8*g +: 8] = regs_q[g];
    end

    always_comb begin
        if (regs_q[0][1])      mode = MODE_BITMAP;
        else if (regs_q[1][4]) mode = MODE_TEXT;
        else if (regs_q[1][3]) mode = MODE_MULTI;
        else                   mode = MODE_TILE;
        disp_en = regs_q[1][6];
        irq_en  = regs_q[1][5];
    end
endmodule

// File: rtl/vhp_vram.sv
module vhp_vram #(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned STORE_AW = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int unsigned DEPTH = 1 << STORE_AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr[STORE_AW-1:0]] <= wdata;
        if (re) rdata <= mem[raddr[STORE_AW-1:0]];
    end
endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
    import vhp_pkg::*;
#(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned STORE_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_ctl,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              frame_evt,
    input  logic              fifth_evt,
    input  logic [4:0]        fifth_idx,
    input  logic              coll_evt,
    output logic [63:0]       regs_o,
    output logic [1:0]        mode_o,
    output logic              disp_en_o,
    output logic              irq_o
);
    logic dat_wr, dat_rd, ctl_wr, st_rd;
    assign dat_wr = acc_en &&  acc_wr && !acc_ctl;
    assign dat_rd = acc_en && !acc_wr && !acc_ctl;
    assign ctl_wr = acc_en &&  acc_wr &&  acc_ctl;
    assign st_rd  = acc_en && !acc_wr &&  acc_ctl;

    stage_e                cmd_stage;
    logic                  reg_we, addr_ld, fetch_req;
    logic [REG_IDX_W-1:0]  reg_idx;
    logic [7:0]            reg_val;
    logic [ADDR_W-1:0]     addr_val;

    vhp_cmd_latch #(.ADDR_W(ADDR_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .stage_clr(dat_wr || dat_rd || st_rd),
        .wbyte(wdata), .stage_o(cmd_stage), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_val(reg_val), .addr_ld(addr_ld), .addr_val(addr_val), .fetch_req(fetch_req)
    );

    vmode_e mode_w;
    logic   irq_en;

    vhp_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx), .val(reg_val),
        .regs_flat(regs_o), .mode(mode_w), .disp_en(disp_en_o), .irq_en(irq_en)
    );
    assign mode_o = mode_w;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] ram_raddr;
    logic [7:0]        ram_q;
    logic              ram_re;

    assign ram_re    = fetch_req || dat_rd;
    assign ram_raddr = fetch_req ? addr_val : addr_q;

    vhp_vram #(.ADDR_W(ADDR_W), .STORE_AW(STORE_AW)) u_vram (
        .clk(clk), .we(dat_wr), .waddr(addr_q), .wdata(wdata),
        .re(ram_re), .raddr(ram_raddr), .rdata(ram_q)
    );

    // prefetch state machine: state register
    pf_e pf_q, pf_d;
    always_comb begin
        pf_d = pf_q;
        unique case (pf_q)
            PF_IDLE: if (ram_re) pf_d = PF_LOAD;
            PF_LOAD: pf_d = ram_re ? PF_LOAD : PF_IDLE;
            default: pf_d = PF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pf_q <= PF_IDLE;
        else        pf_q <= pf_d;
    end

    // data path: pointer, read buffer, status, read data
    logic [7:0] rd_buf_q;
    logic [7:0] status_q, status_d;

    always_comb begin
        status_d = st_rd ? 8'h00 : status_q;
        if (frame_evt) status_d[ST_FRAME_BIT] = 1'b1;
        if (coll_evt)  status_d[ST_COLL_BIT]  = 1'b1;
        if (fifth_evt) begin
            status_d[ST_FIFTH_BIT] = 1'b1;
            status_d[4:0]          = fifth_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            rd_buf_q <= 8'h00;
            status_q <= 8'h00;
            rdata    <= 8'h00;
        end else begin
            status_q <= status_d;
            if (pf_q == PF_LOAD) rd_buf_q <= ram_q;
            if (addr_ld)
                addr_q <= fetch_req ? addr_val + 1'b1 : addr_val;
            else if (dat_wr || dat_rd)
                addr_q <= addr_q + 1'b1;
            if (st_rd)       rdata <= status_q;
            else if (dat_rd) rdata <= rd_buf_q;
        end
    end

    assign irq_o = status_q[ST_FRAME_BIT] && irq_en;
endmodule

// File: rtl/vhp_checker.sv
module vhp_checker
    import vhp_pkg::*;
#(
    parameter int unsigned ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_wr,
    input logic              acc_ctl,
    input logic              frame_evt,
    input logic              fifth_evt,
    input logic              coll_evt,
    input logic              irq,
    input stage_e            stage,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        status,
    input logic [63:0]       regs
);
    logic quiet_st_rd;
    assign quiet_st_rd = acc_en && !acc_wr && acc_ctl && !frame_evt && !fifth_evt && !coll_evt;

    assert_stage_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && (!acc_ctl || !acc_wr)) |=> stage == STAGE_FIRST);

    // R3 / R5: each data access advances the pointer by one, modulo 2^ADDR_W
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_ctl) |=> addr == ADDR_W'($past(addr) + 1'b1));

    assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_st_rd |=> status == 8'h00);

    assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_st_rd |=> !irq);

    assert_regs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && acc_wr && acc_ctl) |=> $stable(regs));
endmodule

bind vdp_host_port vhp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_ctl(acc_ctl),
    .frame_evt(frame_evt), .fifth_evt(fifth_evt), .coll_evt(coll_evt), .irq(irq_o),
    .stage(cmd_stage), .addr(addr_q), .status(status_q), .regs(regs_o)
);

// File: tb/vdp_host_port_tb_top.sv
`timescale 1ns/1ps
module vdp_host_port_tb_top;
    localparam int unsigned ADDR_W   = 14;
    localparam int unsigned STORE_AW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0, acc_ctl = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        frame_evt = 1'b0, fifth_evt = 1'b0, coll_evt = 1'b0;
    logic [4:0]  fifth_idx = 5'd0;
    logic [63:0] regs_o;
    logic [1:0]  mode_o;
    logic        disp_en_o, irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vdp_host_port #(.ADDR_W(ADDR_W), .STORE_AW(STORE_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_ctl(acc_ctl),
        .wdata(wdata), .rdata(rdata), .frame_evt(frame_evt), .fifth_evt(fifth_evt),
        .fifth_idx(fifth_idx), .coll_evt(coll_evt), .regs_o(regs_o), .mode_o(mode_o),
        .disp_en_o(disp_en_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // one access cycle followed by one idle cycle
    task automatic acc(input logic wr, input logic ctl, input logic [7:0] b, output logic [7:0] rd);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_ctl = ctl; wdata = b;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; acc_ctl = 1'b0;
        rd = rdata;
        @(negedge clk);
    endtask

    task automatic ctl_wr(input logic [7:0] b);
        logic [7:0] d;
        acc(1'b1, 1'b1, b, d);
    endtask
    task automatic dat_wr(input logic [7:0] b);
        logic [7:0] d;
        acc(1'b1, 1'b0, b, d);
    endtask
    task automatic dat_rd(output logic [7:0] b);
        acc(1'b0, 1'b0, 8'h00, b);
    endtask
    task automatic st_rd(output logic [7:0] b);
        acc(1'b0, 1'b1, 8'h00, b);
    endtask
    task automatic set_reg(input int idx, input logic [7:0] v);
        ctl_wr(v);
        ctl_wr(8'h80 | 8'(idx));
    endtask
    task automatic set_waddr(input logic [13:0] a);
        ctl_wr(a[7:0]);
        ctl_wr({2'b01, a[13:8]});
    endtask
    task automatic set_raddr(input logic [13:0] a);
        ctl_wr(a[7:0]);
        ctl_wr({2'b00, a[13:8]});
    endtask
    task automatic pulse(input logic f, input logic s, input logic [4:0] i, input logic c);
        @(negedge clk);
        frame_evt = f; fifth_evt = s; fifth_idx = i; coll_evt = c;
        @(negedge clk);
        frame_evt = 1'b0; fifth_evt = 1'b0; coll_evt = 1'b0;
    endtask

    function automatic logic [7:0] reg_of(input int n);
        return regs_o[8*n +: 8];
    endfunction

    task automatic t_reset();
        logic [7:0] s;
        chk("R1 regs", regs_o, 64'h0);
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 mode", mode_o, 2'd0);
        chk("R1 disp", disp_en_o, 1'b0);
        chk("R1 irq", irq_o, 1'b0);
        st_rd(s);
        chk("R1 status", s, 8'h00);
    endtask

    task automatic t_regs();
        for (int i = 0; i < 8; i++) set_reg(i, 8'h55 + 8'(i));
        for (int i = 0; i < 8; i++) chk("R2 reg value", reg_of(i), 8'h55 + 8'(i));
        set_reg(8, 8'hAA);
        chk("R2 index 8 to reg0", reg_of(0), 8'hAA);
        chk("R2 reg1 untouched", reg_of(1), 8'h56);
        for (int i = 0; i < 8; i++) set_reg(i, 8'h00);
    endtask

    task automatic t_mode();
        set_reg(0, 8'h02);
        chk("R9 bitmap", mode_o, 2'd1);
        set_reg(1, 8'h10);
        chk("R9 bitmap over text", mode_o, 2'd1);
        set_reg(0, 8'h00);
        chk("R9 text", mode_o, 2'd2);
        set_reg(1, 8'h18);
        chk("R9 text over multi", mode_o, 2'd2);
        set_reg(1, 8'h08);
        chk("R9 multi", mode_o, 2'd3);
        set_reg(1, 8'h40);
        chk("R9 tile", mode_o, 2'd0);
        chk("R10 display on", disp_en_o, 1'b1);
        set_reg(1, 8'h00);
        chk("R10 display off", disp_en_o, 1'b0);
    endtask

    task automatic t_stream();
        logic [7:0] b;
        set_waddr(14'h0100);
        dat_wr(8'h42); dat_wr(8'h43); dat_wr(8'h44);
        set_raddr(14'h0100);
        dat_rd(b); chk("R4 read 0", b, 8'h42);
        dat_rd(b); chk("R3 R4 read 1", b, 8'h43);
        dat_rd(b); chk("R3 R4 read 2", b, 8'h44);
        set_raddr(14'h0101);
        dat_rd(b); chk("R4 reseek", b, 8'h43);
    endtask

    task automatic t_wrap();
        logic [7:0] b;
        set_waddr(14'h3FFF);
        dat_wr(8'hEE); dat_wr(8'hFF);
        set_raddr(14'h3FFF);
        dat_rd(b); chk("R5 top byte", b, 8'hEE);
        dat_rd(b); chk("R5 read wraps", b, 8'hFF);
        set_raddr(14'h0000);
        dat_rd(b); chk("R5 write wrapped", b, 8'hFF);
    endtask

    task automatic t_alias();
        logic [7:0] b;
        set_waddr(14'h0005);
        dat_wr(8'h5A);
        set_raddr(14'h0405);
        dat_rd(b); chk("R11 alias", b, 8'h5A);
    endtask

    task automatic t_stage();
        logic [7:0] b;
        set_reg(4, 8'h11);
        ctl_wr(8'h42); dat_wr(8'h00);
        set_reg(7, 8'hCC);
        chk("R6 after data write", reg_of(7), 8'hCC);
        chk("R6 reg4 kept", reg_of(4), 8'h11);
        ctl_wr(8'h42); st_rd(b);
        set_reg(7, 8'hDD);
        chk("R6 after status read", reg_of(7), 8'hDD);
        ctl_wr(8'h42); dat_rd(b);
        set_reg(7, 8'hBE);
        chk("R6 after data read", reg_of(7), 8'hBE);
        chk("R6 reg4 still kept", reg_of(4), 8'h11);
        set_reg(4, 8'h00); set_reg(7, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] b;
        pulse(1'b1, 1'b0, 5'd0, 1'b0);
        st_rd(b); chk("R8 frame flag", b, 8'h80);
        st_rd(b); chk("R7 cleared", b, 8'h00);
        pulse(1'b0, 1'b1, 5'd4, 1'b1);
        st_rd(b); chk("R8 fifth and collision", b, 8'h64);
        // event in the same cycle as the status read
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_ctl = 1'b1; frame_evt = 1'b1;
        @(negedge clk);
        acc_en = 1'b0; acc_ctl = 1'b0; frame_evt = 1'b0;
        chk("R7 read returns old", rdata, 8'h00);
        @(negedge clk);
        st_rd(b); chk("R7 same-cycle set kept", b, 8'h80);
    endtask

    task automatic t_irq();
        logic [7:0] b;
        set_reg(1, 8'h60);
        chk("R10 irq idle", irq_o, 1'b0);
        pulse(1'b1, 1'b0, 5'd0, 1'b0);
        chk("R10 irq raised", irq_o, 1'b1);
        st_rd(b);
        chk("R10 irq dropped", irq_o, 1'b0);
        set_reg(1, 8'h40);
        pulse(1'b1, 1'b0, 5'd0, 1'b0);
        chk("R10 irq masked", irq_o, 1'b0);
        st_rd(b); chk("R10 flag without irq", b, 8'h80);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_mode();
        t_stream();
        t_wrap();
        t_alias();
        t_stage();
        t_status();
        t_irq();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=hung exp=complete");
            summary();
            $finish;
        end
    end
endmodule